// File: doc/BRIEF.md
# Laser Array Safety Control Sequencer

This block supervises the output enables of a multi-channel laser transmitter array. It takes an active-high enable, an active-high disable, an active-low control reset and three fault flags (drive over-current, temperature out of range, corrupted calibration data). From these it produces one enable per laser channel and an active-low fault output. Every control input crosses into the clock domain through a two-flop synchroniser before any decision is made.

An enable or disable request only counts once it has been held for a minimum number of cycles. Any detected fault is latched, pulls the fault output low and removes every channel enable. Only the control reset or a power-on reset clears the latch. While the array is allowed to run, the channels switch on one at a time in ascending index order. After power-up the first channel waits a long initial delay. After a re-enable or a reset release it waits a slightly shorter one. Each later channel follows a fixed step, and after a restart the first step is shorter. All delays are cycle counts set by parameters.

Top module: `laser_safety_seq`

## Requirements
- R1: Holding `tx_on_i` low, or `tx_off_i` high, for at least `HOLD_CYC` clock cycles forces all of `ch_en_o` to 0. With the input changed between edges at cycle c, the enables are still set at cycle c+1+HOLD_CYC and are 0 at cycle c+2+HOLD_CYC.
- R2: A low pulse on `tx_on_i`, or a high pulse on `tx_off_i`, that lasts `HOLD_CYC`-1 cycles leaves `ch_en_o` and `fault_n_o` unchanged.
- R3: After power-on reset is released with `tx_on_i` high and no fault, channel 0 turns on `COLD_CYC` cycles after the release. Each next channel turns on `STEP_CYC` cycles after the one before it. Directly after the release, `ch_en_o` is 0 and `fault_n_o` is 1.
- R4: After a shutdown request is withdrawn, channel 0 turns on 3+`WARM_CYC` cycles later. After a control reset is released, channel 0 turns on 2+`WARM_CYC` cycles later. Channel 1 follows `STEP1_CYC` cycles after channel 0, and each later channel follows `STEP_CYC` cycles after the one before.
- R5: A fault flag that is high for at least one cycle, on any of the three fault inputs, drives `fault_n_o` to 0 and all of `ch_en_o` to 0 three cycles after it rises.
- R6: Once set, the fault stays latched: `fault_n_o` stays 0 and `ch_en_o` stays 0 after the flag falls and after the enable is cycled.
- R7: `ctl_rst_n_i` low, even for a single cycle, clears `ch_en_o` two cycles later and sets `fault_n_o` to 1 three cycles later. Fault flags seen while the reset is low are ignored.
- R8: A shutdown cause that arrives during the staggered turn-on aborts it at once. When the cause clears, the sequence restarts from channel 0 with the restart delays of R4.
- R9: Channels turn on in ascending index order, at most one per cycle. `ch_en_o` is always a contiguous run of ones starting at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pwr_n | input | 1 | Power-on reset, active low, asynchronous |
| tx_on_i | input | 1 | Array enable request, active high, asynchronous |
| tx_off_i | input | 1 | Array disable request, active high, asynchronous |
| ctl_rst_n_i | input | 1 | Control reset, active low, asynchronous; clears the fault latch |
| flt_ocur_i | input | 1 | Drive over-current flag |
| flt_temp_i | input | 1 | Temperature out-of-range flag |
| flt_cal_i | input | 1 | Calibration data corruption flag |
| ch_en_o | output | NCH | Per-channel laser enable, bit i for channel i |
| fault_n_o | output | 1 | Latched fault indication, active low |

## Verification
The assertions assume that power-on reset is applied at start-up. They also assume that every asynchronous input stays stable for at least one full clock period once it changes, so that each synchroniser sees the value. The stimulus changes inputs only at falling clock edges and never makes a pulse shorter than one period. This includes the single-cycle control reset and fault-flag pulses, which the checks use as the narrowest legal events.

// File: rtl/laser_safety_seq.sv
`timescale 1ns/1ps
module laser_safety_seq #(
  parameter int NCH       = 12,
  parameter int COLD_CYC  = 12_000_000,
  parameter int WARM_CYC  = 11_000_000,
  parameter int STEP1_CYC = 840_000,
  parameter int STEP_CYC  = 920_000,
  parameter int HOLD_CYC  = 200_000
) (
  input  logic           clk,
  input  logic           rst_pwr_n,
  input  logic           tx_on_i,
  input  logic           tx_off_i,
  input  logic           ctl_rst_n_i,
  input  logic           flt_ocur_i,
  input  logic           flt_temp_i,
  input  logic           flt_cal_i,
  output logic [NCH-1:0] ch_en_o,
  output logic           fault_n_o
);
  localparam int MAX_A = (COLD_CYC > WARM_CYC) ? COLD_CYC : WARM_CYC;
  localparam int MAX_B = (STEP_CYC > STEP1_CYC) ? STEP_CYC : STEP1_CYC;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW = $clog2(MAX_C + 1);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam int CW = $clog2(NCH + 1);

  logic [1:0] on_sy, off_sy, rst_sy;
  logic [2:0] flt_s1, flt_s2;
  logic on_s, off_s, rst_s_n, flt_any_s;

  always_ff @(posedge clk or negedge rst_pwr_n)
    if (!rst_pwr_n) begin
      on_sy  <= 2'b00;
      off_sy <= 2'b00;
      rst_sy <= 2'b11;
      flt_s1 <= '0;
      flt_s2 <= '0;
    end else begin
      on_sy  <= {on_sy[0], tx_on_i};
      off_sy <= {off_sy[0], tx_off_i};
      rst_sy <= {rst_sy[0], ctl_rst_n_i};
      flt_s1 <= {flt_cal_i, flt_temp_i, flt_ocur_i};
      flt_s2 <= flt_s1;
    end

  assign on_s      = on_sy[1];
  assign off_s     = off_sy[1];
  assign rst_s_n   = rst_sy[1];
  assign flt_any_s = |flt_s2;

  logic          req_raw, off_q, fault_q, cold_q, blocked;
  logic [HW-1:0] hcnt;
  logic [TW-1:0] tmr, tgt_m1;
  logic [CW-1:0] on_cnt;

  assign req_raw = ~on_s | off_s;

  always_ff @(posedge clk or negedge rst_pwr_n)
    if (!rst_pwr_n) begin
      hcnt  <= '0;
      off_q <= 1'b0;
    end else if (!req_raw) begin
      hcnt  <= '0;
      off_q <= 1'b0;
    end else if (!off_q) begin
      if (hcnt == HW'(HOLD_CYC - 1)) off_q <= 1'b1;
      else hcnt <= hcnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_pwr_n)
    if (!rst_pwr_n)   fault_q <= 1'b0;
    else if (!rst_s_n) fault_q <= 1'b0;
    else if (flt_any_s) fault_q <= 1'b1;

  assign blocked = off_q | fault_q | ~rst_s_n;

  always_comb
    if (on_cnt == '0)           tgt_m1 = cold_q ? TW'(COLD_CYC - 1) : TW'(WARM_CYC - 1);
    else if (on_cnt == CW'(1) && !cold_q) tgt_m1 = TW'(STEP1_CYC - 1);
    else                        tgt_m1 = TW'(STEP_CYC - 1);

  always_ff @(posedge clk or negedge rst_pwr_n)
    if (!rst_pwr_n) begin
      cold_q <= 1'b1;
      on_cnt <= '0;
      tmr    <= '0;
    end else if (blocked) begin
      cold_q <= 1'b0;
      on_cnt <= '0;
      tmr    <= '0;
    end else if (on_cnt != CW'(NCH)) begin
      if (tmr == tgt_m1) begin
        on_cnt <= on_cnt + 1'b1;
        tmr    <= '0;
      end else begin
        tmr <= tmr + 1'b1;
      end
    end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ch_en_o[g] = ~blocked & (on_cnt > CW'(g));
  end

  assign fault_n_o = ~fault_q;
endmodule

module laser_safety_seq_chk #(
  parameter int NCH = 12
) (
  input logic           clk,
  input logic           rst_pwr_n,
  input logic           rst_s_n,
  input logic           flt_any_s,
  input logic           off_q,
  input logic [NCH-1:0] ch_en_o,
  input logic           fault_n_o
);
  // R1
  off_held_dark_chk: assert property (@(posedge clk) disable iff (!rst_pwr_n)
    off_q |-> ch_en_o == '0);
  // R5
  fault_sets_chk: assert property (@(posedge clk) disable iff (!rst_pwr_n)
    (flt_any_s && rst_s_n) |=> !fault_n_o);
  // R5
  fault_dark_chk: assert property (@(posedge clk) disable iff (!rst_pwr_n)
    !fault_n_o |-> ch_en_o == '0);
  // R6
  fault_latched_chk: assert property (@(posedge clk) disable iff (!rst_pwr_n)
    (!fault_n_o && rst_s_n) |=> !fault_n_o);
  // R7
  reset_dark_chk: assert property (@(posedge clk) disable iff (!rst_pwr_n)
    !rst_s_n |-> ch_en_o == '0);
  // R7
  reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_pwr_n)
    !rst_s_n |=> fault_n_o);
  // R9
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_pwr_n)
    $countones(ch_en_o & ~$past(ch_en_o)) <= 1);
  // R9
  first_rise_chk: assert property (@(posedge clk) disable iff (!rst_pwr_n)
    $rose(ch_en_o[0]) |-> $past(ch_en_o) == '0);
endmodule

bind laser_safety_seq laser_safety_seq_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_pwr_n(rst_pwr_n), .rst_s_n(rst_s_n), .flt_any_s(flt_any_s),
  .off_q(off_q), .ch_en_o(ch_en_o), .fault_n_o(fault_n_o)
);

// File: tb/laser_safety_seq_bench.sv
`timescale 1ns/1ps
module laser_safety_seq_bench;
  localparam int NCH = 12, COLD = 40, WARM = 30, F1 = 6, ST = 10, HOLD = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_pwr_n = 1'b0, tx_on_i = 1'b1, tx_off_i = 1'b0, ctl_rst_n_i = 1'b1;
  logic flt_ocur_i = 1'b0, flt_temp_i = 1'b0, flt_cal_i = 1'b0;
  logic [NCH-1:0] ch_en_o;
  logic fault_n_o;

  laser_safety_seq #(.NCH(NCH), .COLD_CYC(COLD), .WARM_CYC(WARM), .STEP1_CYC(F1),
                     .STEP_CYC(ST), .HOLD_CYC(HOLD)) u_laser_safety_seq (
    .clk(clk), .rst_pwr_n(rst_pwr_n), .tx_on_i(tx_on_i), .tx_off_i(tx_off_i),
    .ctl_rst_n_i(ctl_rst_n_i), .flt_ocur_i(flt_ocur_i), .flt_temp_i(flt_temp_i),
    .flt_cal_i(flt_cal_i), .ch_en_o(ch_en_o), .fault_n_o(fault_n_o));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int at; logic [NCH-1:0] m; logic fn; string tag; } exp_t;
  exp_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  function automatic logic [NCH-1:0] msk(int n);
    logic [NCH-1:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = 1'b1;
    return r;
  endfunction

  task automatic put(int at, int n, logic fn, string tag);
    exp_t e;
    e.at = at; e.m = msk(n); e.fn = fn; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic ramp(int t0, int f, int upto, string tag);
    for (int i = 0; i < upto; i++) begin
      int t;
      t = (i == 0) ? t0 : t0 + f + (i - 1) * ST;
      put(t - 1, i, 1'b1, tag);
      put(t, i + 1, 1'b1, tag);
    end
  endtask

  task automatic wait_to(int n);
    while (cyc < n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    exp_t e;
    #1;
    while (q.size() > 0 && q[0].at <= cyc) begin
      e = q.pop_front();
      n_cmp++;
      if (e.at != cyc || ch_en_o !== e.m || fault_n_o !== e.fn) begin
        n_bad++;
        $display("FAIL %s at cycle %0d (due %0d): ch_en=%h fault_n=%b, expected ch_en=%h fault_n=%b",
                 e.tag, cyc, e.at, ch_en_o, fault_n_o, e.m, e.fn);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int c, d, t0;
    repeat (3) @(negedge clk);
    rst_pwr_n = 1'b1;
    c = cyc;
    put(c, 0, 1'b1, "R3 reset state");
    ramp(c + COLD, ST, NCH, "R3/R9 cold ramp");
    wait_to(c + COLD + (NCH - 1) * ST + 2);

    // R2 short enable drop and short disable pulse
    c = cyc; tx_on_i = 1'b0;
    repeat (HOLD - 1) @(negedge clk);
    tx_on_i = 1'b1;
    put(c + 2 + HOLD, NCH, 1'b1, "R2 short enable drop");
    put(c + 6 + HOLD, NCH, 1'b1, "R2 short enable drop");
    wait_to(c + 8 + HOLD);
    c = cyc; tx_off_i = 1'b1;
    repeat (HOLD - 1) @(negedge clk);
    tx_off_i = 1'b0;
    put(c + 2 + HOLD, NCH, 1'b1, "R2 short disable pulse");
    put(c + 6 + HOLD, NCH, 1'b1, "R2 short disable pulse");
    wait_to(c + 8 + HOLD);

    // R1 enable held low, R4 re-enable
    c = cyc; tx_on_i = 1'b0;
    put(c + 1 + HOLD, NCH, 1'b1, "R1 enable low");
    put(c + 2 + HOLD, 0, 1'b1, "R1 enable low");
    wait_to(c + 20);
    tx_on_i = 1'b1; c = cyc;
    t0 = c + 3 + WARM;
    ramp(t0, F1, NCH, "R4/R9 re-enable ramp");
    wait_to(t0 + F1 + (NCH - 2) * ST + 2);

    // R1 disable held high
    c = cyc; tx_off_i = 1'b1;
    put(c + 1 + HOLD, NCH, 1'b1, "R1 disable high");
    put(c + 2 + HOLD, 0, 1'b1, "R1 disable high");
    wait_to(c + 20);
    tx_off_i = 1'b0; c = cyc;
    t0 = c + 3 + WARM;
    ramp(t0, F1, 3, "R4 disable withdrawn");
    wait_to(t0 + F1 + ST);

    // R8 abort mid-ramp with three channels on
    c = cyc; tx_on_i = 1'b0;
    put(c + 1 + HOLD, 3, 1'b1, "R8 abort");
    put(c + 2 + HOLD, 0, 1'b1, "R8 abort");
    wait_to(c + 15);
    tx_on_i = 1'b1; c = cyc;
    t0 = c + 3 + WARM;
    ramp(t0, F1, NCH, "R8 restart ramp");
    wait_to(t0 + F1 + (NCH - 2) * ST + 2);

    // R5 temperature fault, R6 latch
    c = cyc; flt_temp_i = 1'b1;
    put(c + 2, NCH, 1'b1, "R5 temperature fault");
    put(c + 3, 0, 1'b0, "R5 temperature fault");
    wait_to(c + 5);
    flt_temp_i = 1'b0;
    put(c + 12, 0, 1'b0, "R6 flag removed");
    wait_to(c + 12);
    tx_on_i = 1'b0;
    repeat (HOLD + 6) @(negedge clk);
    tx_on_i = 1'b1; c = cyc;
    put(c + 8 + WARM, 0, 1'b0, "R6 enable cycled");
    wait_to(c + 8 + WARM);

    // R7 single-cycle control reset
    d = cyc; ctl_rst_n_i = 1'b0;
    @(negedge clk);
    ctl_rst_n_i = 1'b1;
    put(d + 2, 0, 1'b0, "R7 reset pulse");
    put(d + 3, 0, 1'b1, "R7 fault cleared");
    t0 = d + 3 + WARM;
    ramp(t0, F1, 3, "R7 restart");
    wait_to(t0 + F1 + ST);

    // R5 single-cycle calibration fault mid-ramp
    c = cyc; flt_cal_i = 1'b1;
    @(negedge clk);
    flt_cal_i = 1'b0;
    put(c + 2, 3, 1'b1, "R5 calibration fault");
    put(c + 3, 0, 1'b0, "R5 calibration fault");
    wait_to(c + 6);

    // R7 held reset, fault flag during reset ignored
    d = cyc; ctl_rst_n_i = 1'b0;
    put(d + 2, 0, 1'b0, "R7 held reset");
    put(d + 3, 0, 1'b1, "R7 held reset");
    @(negedge clk);
    flt_ocur_i = 1'b1;
    repeat (3) @(negedge clk);
    flt_ocur_i = 1'b0;
    repeat (4) @(negedge clk);
    ctl_rst_n_i = 1'b1;
    put(d + 9, 0, 1'b1, "R7 flag during reset ignored");
    t0 = d + 10 + WARM;
    ramp(t0, F1, NCH, "R4 reset release ramp");
    wait_to(t0 + F1 + (NCH - 2) * ST + 2);

    // R5 over-current fault at full array
    c = cyc; flt_ocur_i = 1'b1;
    repeat (2) @(negedge clk);
    flt_ocur_i = 1'b0;
    put(c + 2, NCH, 1'b1, "R5 over-current fault");
    put(c + 3, 0, 1'b0, "R5 over-current fault");
    wait_to(c + 6);

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule